// File: doc/BRIEF.md
# Half-Rate DDR Output Serializer

This block turns half-rate parallel write data from the core into double-data-rate bit streams for one memory byte lane. The lane has eight data pins and one strobe pin. Every pin receives a 4-bit word and a 2-bit output enable once per half-rate period. Each word goes through two cascaded DDR register stages. An even/odd pair of half-rate cells splits the word into two streams, and one full-rate cell then interleaves those streams. The result is four bits per half-rate period on the pin, least significant bit first.

The whole block runs from one bit-rate clock, `clk_bit`. Its period is one bit time, so the half-rate word period is four `clk_bit` cycles and the full-rate period is two. A free-running phase counter supplies the clock enables for each stage. After the serializer, every pin's data and output enable pass through two programmable delay stages in series. Each stage delays by a 4-bit tap count of `clk_bit` cycles, and a count of zero bypasses it. The delayed enable controls the tristate driver of the pad. The driven value and the enable are also available as plain outputs.

Capture timing is fixed relative to reset. The internal reset is released two `clk_bit` edges after `rst_n` rises. A word is captured on the third edge after the release of `rst_n` and then on every fourth edge.

Top module: `ddr_hr_out_lane`

## Requirements
- R1: While `rst_n` is low, and until the first captured bit reaches the output, every `dq_drv`, `dq_en`, `dqs_drv` and `dqs_en` bit is 0.
- R2: A pin emits its 4-bit word in bit order 0, 1, 2, 3, one bit per `clk_bit` cycle. The bits are nibble `4p+3:4p` of `dq_wdata` for DQ pin p, and `dqs_wdata` for the strobe.
- R3: With both taps at 0, bit k of a word captured on edge t appears on the output after edge t+3+k. Capture edges are the third edge after `rst_n` rises and every fourth edge after it.
- R4: Output enable bit 0 of a pin covers data bits 0 and 1, and enable bit 1 covers bits 2 and 3. DQ pin p uses bits `2p+1:2p` of `dq_wen`, and the strobe uses `dqs_wen`.
- R5: When a pin's enable output is 1, its pad carries the driven value. When the enable is 0, the pad is released to high impedance.
- R6: A tap setting of 0 adds no delay to its stage.
- R7: A tap setting of n from 1 to 15 delays both data and enable by n `clk_bit` cycles, and the delays of the two stages add.
- R8: Each pin's taps act only on that pin. For DQ pin p the taps are bits `4p+3:4p` of `dq_tap_a` and `dq_tap_b`.
- R9: When every DQ nibble, enable pair and tap pair is identical, all eight DQ outputs toggle identically in every cycle.
- R10: The strobe pin uses the same serializer, enable and delay behaviour, with its own data, enable and taps.
- R11: Pulling `rst_n` low in the middle of a stream clears all driven values and enables at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dq_wdata | input | 32 | Half-rate data, 4 bits per DQ pin |
| dq_wen | input | 16 | Half-rate output enables, 2 per DQ pin |
| dqs_wdata | input | 4 | Half-rate strobe data |
| dqs_wen | input | 2 | Half-rate strobe output enables |
| dq_tap_a | input | 32 | First delay stage taps, 4 per DQ pin |
| dq_tap_b | input | 32 | Second delay stage taps, 4 per DQ pin |
| dqs_tap_a | input | 4 | First delay stage tap of the strobe |
| dqs_tap_b | input | 4 | Second delay stage tap of the strobe |
| dq_drv | output | 8 | Serialized, delayed DQ values |
| dq_en | output | 8 | Serialized, delayed DQ output enables |
| dqs_drv | output | 1 | Serialized, delayed strobe value |
| dqs_en | output | 1 | Serialized, delayed strobe enable |
| dq_pad | inout | 8 | Tristated DQ pads |
| dqs_pad | inout | 1 | Tristated strobe pad |

## Verification
The hardest case to reach from the ports is a set of pins with different total delays, from 0 up to 30 cycles, alternating between driven and released in the same window. In that case a wrong tap index or a stage that skews the enable against the data shows up only on some pins and only in some cycles. The stimulus resets the lane, sets a different pair of taps on each pin, and streams words whose enables change every half period. It then compares every pin in every cycle against a reference stream computed from the capture-edge rule. A separate run pulls reset between clock edges while the stream is active, to show that the outputs clear asynchronously.

// File: rtl/ddr_hr_out_pkg.sv
package ddr_hr_out_pkg;
  localparam int HR_BITS = 4;
  localparam int HR_OES  = 2;
  localparam int STAGES  = 2;

  typedef logic [1:0] phase_t;

  typedef struct packed {
    logic oe;
    logic d;
  } slot_t;
endpackage

// File: rtl/ddr_rst_sync.sv
module ddr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_nxt;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ddr_phase_gen.sv
module ddr_phase_gen
  import ddr_hr_out_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t ph
);
  phase_t ph_q;
  phase_t ph_nxt;

  always_comb begin
    ph_nxt = ph_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_nxt;
  end

  assign ph = ph_q;

  // R3: the word period is exactly four bit cycles
  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ph_q) == 2'd3 |-> ph_q == 2'd0);
endmodule

// File: rtl/ddr_tap_delay.sv
module ddr_tap_delay
  import ddr_hr_out_pkg::*;
#(
  parameter int TAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAP_W-1:0] tap,
  input  slot_t            din,
  output slot_t            dout
);
  localparam int DEPTH = (1 << TAP_W) - 1;
  localparam logic [TAP_W-1:0] TAP_ONE = {{(TAP_W-1){1'b0}}, 1'b1};

  slot_t sr_q   [0:DEPTH-1];
  slot_t sr_nxt [0:DEPTH-1];

  always_comb begin
    sr_nxt[0] = din;
    for (int i = 1; i < DEPTH; i++) sr_nxt[i] = sr_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= sr_nxt[i];
    end
  end

  always_comb begin
    if (tap == '0) dout = din;
    else           dout = sr_q[tap - TAP_ONE];
  end

  // R7: a steady tap of one gives exactly one cycle of delay
  assert_one_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tap == TAP_ONE && $past(tap) == TAP_ONE) |-> dout == $past(din));

  // R7: a steady tap of two gives exactly two cycles of delay
  assert_two_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tap == (TAP_ONE << 1) && $past(tap) == tap && $past(tap, 2) == tap)
      |-> dout == $past(din, 2));
endmodule

// File: rtl/ddr_pin_ser.sv
module ddr_pin_ser
  import ddr_hr_out_pkg::*;
#(
  parameter int TAP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  phase_t             ph,
  input  logic [HR_BITS-1:0] wdata,
  input  logic [HR_OES-1:0]  wen,
  input  logic [TAP_W-1:0]   tap_a,
  input  logic [TAP_W-1:0]   tap_b,
  output logic               drv,
  output logic               en
);
  logic [HR_BITS-1:0] word_q, word_nxt;
  logic [HR_OES-1:0]  wen_q,  wen_nxt;
  slot_t hi_q, hi_nxt;
  slot_t lo_q, lo_nxt;
  slot_t fr_q, fr_nxt;
  logic  cap_en;
  logic  hr_en;

  // Clock enables: capture once per word, half-rate cells twice per word
  assign cap_en = (ph == 2'd0);
  assign hr_en  = ~ph[0];

  always_comb begin
    word_nxt = word_q;
    wen_nxt  = wen_q;
    if (cap_en) begin
      word_nxt = wdata;
      wen_nxt  = wen;
    end
  end

  // Half-rate cells: even bits to the high cell, odd bits to the low cell
  always_comb begin
    hi_nxt = hi_q;
    lo_nxt = lo_q;
    if (hr_en) begin
      if (ph == 2'd2) begin
        hi_nxt = '{oe: wen_q[0], d: word_q[0]};
        lo_nxt = '{oe: wen_q[0], d: word_q[1]};
      end else begin
        hi_nxt = '{oe: wen_q[1], d: word_q[2]};
        lo_nxt = '{oe: wen_q[1], d: word_q[3]};
      end
    end
  end

  // Full-rate cell: high stream in the first bit slot, low stream in the second
  always_comb begin
    fr_nxt = ph[0] ? hi_q : lo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      wen_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      fr_q   <= '0;
    end else begin
      word_q <= word_nxt;
      wen_q  <= wen_nxt;
      hi_q   <= hi_nxt;
      lo_q   <= lo_nxt;
      fr_q   <= fr_nxt;
    end
  end

  slot_t chain [0:STAGES];
  assign chain[0] = fr_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    ddr_tap_delay #(.TAP_W(TAP_W)) u_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .tap  ((s == 0) ? tap_a : tap_b),
      .din  (chain[s]),
      .dout (chain[s+1])
    );
  end

  assign drv = chain[STAGES].d;
  assign en  = chain[STAGES].oe;

  // R2: bit 0 of the held word leaves the full-rate cell in the slot before the next capture
  assert_bit0_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ph == 2'd0 |-> fr_q.d == word_q[0]);

  // R2: bit 1 of the previous word follows in the next slot
  assert_bit1_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ph == 2'd1 |-> fr_q.d == $past(word_q[1]));

  // R4: enable bit 0 travels with the first two bits
  assert_oe_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ph == 2'd0 |-> fr_q.oe == wen_q[0]);
endmodule

// File: rtl/ddr_hr_out_lane.sv
module ddr_hr_out_lane
  import ddr_hr_out_pkg::*;
#(
  parameter int NUM_DQ = 8,
  parameter int TAP_W  = 4
) (
  input  logic                      clk_bit,
  input  logic                      rst_n,
  input  logic [NUM_DQ*HR_BITS-1:0] dq_wdata,
  input  logic [NUM_DQ*HR_OES-1:0]  dq_wen,
  input  logic [HR_BITS-1:0]        dqs_wdata,
  input  logic [HR_OES-1:0]         dqs_wen,
  input  logic [NUM_DQ*TAP_W-1:0]   dq_tap_a,
  input  logic [NUM_DQ*TAP_W-1:0]   dq_tap_b,
  input  logic [TAP_W-1:0]          dqs_tap_a,
  input  logic [TAP_W-1:0]          dqs_tap_b,
  output logic [NUM_DQ-1:0]         dq_drv,
  output logic [NUM_DQ-1:0]         dq_en,
  output logic                      dqs_drv,
  output logic                      dqs_en,
  inout  wire  [NUM_DQ-1:0]         dq_pad,
  inout  wire                       dqs_pad
);
  logic   core_rst_n;
  phase_t ph;

  ddr_rst_sync u_rst (
    .clk   (clk_bit),
    .arst_n(rst_n),
    .srst_n(core_rst_n)
  );

  ddr_phase_gen u_phase (
    .clk  (clk_bit),
    .rst_n(core_rst_n),
    .ph   (ph)
  );

  for (genvar p = 0; p < NUM_DQ; p++) begin : g_dq
    ddr_pin_ser #(.TAP_W(TAP_W)) u_pin (
      .clk  (clk_bit),
      .rst_n(core_rst_n),
      .ph   (ph),
      .wdata(dq_wdata[p*HR_BITS +: HR_BITS]),
      .wen  (dq_wen[p*HR_OES +: HR_OES]),
      .tap_a(dq_tap_a[p*TAP_W +: TAP_W]),
      .tap_b(dq_tap_b[p*TAP_W +: TAP_W]),
      .drv  (dq_drv[p]),
      .en   (dq_en[p])
    );

    assign dq_pad[p] = dq_en[p] ? dq_drv[p] : 1'bz;

    // R5: an enabled pad carries the serialized value
    assert_pad_follow_R5: assert property (@(posedge clk_bit) disable iff (!core_rst_n)
      dq_en[p] |-> dq_pad[p] == dq_drv[p]);
  end

  ddr_pin_ser #(.TAP_W(TAP_W)) u_strobe (
    .clk  (clk_bit),
    .rst_n(core_rst_n),
    .ph   (ph),
    .wdata(dqs_wdata),
    .wen  (dqs_wen),
    .tap_a(dqs_tap_a),
    .tap_b(dqs_tap_b),
    .drv  (dqs_drv),
    .en   (dqs_en)
  );

  assign dqs_pad = dqs_en ? dqs_drv : 1'bz;

  // R1: nothing is enabled while the internal reset is held
  assert_quiet_reset_R1: assert property (@(posedge clk_bit)
    !core_rst_n |-> (dq_en == '0 && dqs_en == 1'b0));
endmodule

// File: tb/sim_ddr_hr_out_lane.sv
module sim_ddr_hr_out_lane;
  localparam int CLK_T = 10;
  localparam int NW    = 16;
  localparam int NCYC  = 6 + 4*NW + 34;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] dq_wdata;
  logic [15:0] dq_wen;
  logic [3:0]  dqs_wdata;
  logic [1:0]  dqs_wen;
  logic [31:0] dq_tap_a, dq_tap_b;
  logic [3:0]  dqs_tap_a, dqs_tap_b;
  logic [7:0]  dq_drv, dq_en;
  logic        dqs_drv, dqs_en;
  wire  [7:0]  dq_pad;
  wire         dqs_pad;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] wd [0:NW-1];
  logic [15:0] we [0:NW-1];
  logic [3:0]  sd [0:NW-1];
  logic [1:0]  se [0:NW-1];
  logic [3:0]  ta [0:8];
  logic [3:0]  tb [0:8];

  always #(CLK_T/2) clk = ~clk;

  ddr_hr_out_lane u0 (
    .clk_bit  (clk),
    .rst_n    (rst_n),
    .dq_wdata (dq_wdata),
    .dq_wen   (dq_wen),
    .dqs_wdata(dqs_wdata),
    .dqs_wen  (dqs_wen),
    .dq_tap_a (dq_tap_a),
    .dq_tap_b (dq_tap_b),
    .dqs_tap_a(dqs_tap_a),
    .dqs_tap_b(dqs_tap_b),
    .dq_drv   (dq_drv),
    .dq_en    (dq_en),
    .dqs_drv  (dqs_drv),
    .dqs_en   (dqs_en),
    .dq_pad   (dq_pad),
    .dqs_pad  (dqs_pad)
  );

  task automatic chk(input string req, input string what, input int pin, input int n,
                     input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s pin%0d edge%0d act=%0b exp=%0b", req, what, pin, n, act, exp);
    end
  endtask

  function automatic logic ref_bit(input int p, input int n, input bit want_oe);
    int d, m, j, k;
    d = int'(ta[p]) + int'(tb[p]);
    m = n - d - 6;
    if (m < 0) return 1'b0;
    j = m / 4;
    k = m % 4;
    if (j >= NW) return 1'b0;
    if (want_oe) return (p < 8) ? we[j][2*p + k/2] : se[j][k/2];
    return (p < 8) ? wd[j][4*p + k] : sd[j][k];
  endfunction

  task automatic fill(input int seed, input bit all_on);
    for (int j = 0; j < NW; j++) begin
      wd[j] = (32'h2545F491 * (j + seed + 1)) ^ (32'h9E3779B9 >> j);
      sd[j] = 4'(j + seed) ^ 4'b0101;
      if (all_on) begin
        we[j] = '1;
        se[j] = '1;
      end else begin
        we[j] = 16'(32'h6A09E667 * (j + seed + 3));
        se[j] = 2'(j + seed);
      end
    end
  endtask

  task automatic set_taps(input int mode);
    for (int p = 0; p < 9; p++) begin
      case (mode)
        0: begin ta[p] = 4'd0;             tb[p] = 4'd0; end
        1: begin ta[p] = 4'(p * 2);        tb[p] = 4'(15 - p); end
        default: begin ta[p] = 4'd3;       tb[p] = 4'd5; end
      endcase
    end
    if (mode == 1) begin
      ta[0] = 4'd0;  tb[0] = 4'd0;
      ta[1] = 4'd1;  tb[1] = 4'd0;
      ta[2] = 4'd0;  tb[2] = 4'd15;
      ta[3] = 4'd15; tb[3] = 4'd15;
    end
    for (int p = 0; p < 8; p++) begin
      dq_tap_a[4*p +: 4] = ta[p];
      dq_tap_b[4*p +: 4] = tb[p];
    end
    dqs_tap_a = ta[8];
    dqs_tap_b = tb[8];
  endtask

  task automatic drive_word(input int j);
    if (j < NW) begin
      dq_wdata = wd[j]; dq_wen = we[j]; dqs_wdata = sd[j]; dqs_wen = se[j];
    end else begin
      dq_wdata = '0; dq_wen = '0; dqs_wdata = '0; dqs_wen = '0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive_word(NW);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_all(input string req, input int n, input bit same);
    for (int p = 0; p < 9; p++) begin
      logic ed, ee, ad, ae, ap;
      ed = ref_bit(p, n, 1'b0);
      ee = ref_bit(p, n, 1'b1);
      ad = (p < 8) ? dq_drv[p] : dqs_drv;
      ae = (p < 8) ? dq_en[p]  : dqs_en;
      ap = (p < 8) ? dq_pad[p] : dqs_pad;
      chk(req, "drv", p, n, ad, ed);
      chk(req, "en",  p, n, ae, ee);
      if (ee) chk({req, " R5"}, "pad", p, n, ap, ed);
      if (same && p > 0 && p < 8) begin
        chk({req, " R9"}, "match", p, n, dq_drv[p], dq_drv[0]);
        chk({req, " R9"}, "match_en", p, n, dq_en[p], dq_en[0]);
      end
    end
  endtask

  task automatic stream(input string req, input int ncyc, input bit same);
    do_reset();
    for (int n = 1; n <= ncyc; n++) begin
      int c;
      @(posedge clk);
      @(negedge clk);
      check_all(req, n, same);
      c = n + 1 - 3;
      if (c >= 0 && c % 4 == 0) drive_word(c / 4);
    end
  endtask

  task automatic test_reset_R1();
    fill(1, 1'b1);
    set_taps(0);
    rst_n = 1'b0;
    drive_word(0);
    repeat (4) begin
      @(negedge clk);
      chk("R1", "drv_rst", 0, 0, |{dq_drv, dqs_drv}, 1'b0);
      chk("R1", "en_rst",  0, 0, |{dq_en, dqs_en}, 1'b0);
    end
    stream("R1 R3", 8, 1'b0);
  endtask

  task automatic test_order_R2_R3();
    fill(2, 1'b1);
    set_taps(0);
    stream("R2 R3 R6", NCYC, 1'b0);
  endtask

  task automatic test_oe_R4_R5();
    fill(5, 1'b0);
    set_taps(0);
    stream("R4 R5", NCYC, 1'b0);
  endtask

  task automatic test_taps_R7_R8();
    fill(9, 1'b0);
    set_taps(1);
    stream("R6 R7 R8", NCYC, 1'b0);
  endtask

  task automatic test_same_R9();
    fill(3, 1'b0);
    for (int j = 0; j < NW; j++) begin
      wd[j] = {8{wd[j][3:0]}};
      we[j] = {8{we[j][1:0]}};
    end
    set_taps(2);
    stream("R9", NCYC, 1'b1);
  endtask

  task automatic test_strobe_R10();
    fill(7, 1'b0);
    for (int j = 0; j < NW; j++) sd[j] = 4'b1010 ^ 4'(j);
    set_taps(1);
    ta[8] = 4'd6; tb[8] = 4'd9;
    dqs_tap_a = ta[8]; dqs_tap_b = tb[8];
    stream("R10", NCYC, 1'b0);
  endtask

  task automatic test_midreset_R11();
    fill(4, 1'b1);
    set_taps(0);
    stream("R11", 30, 1'b0);
    #(CLK_T/4);
    rst_n = 1'b0;
    #1;
    chk("R11", "drv_async", 0, 30, |{dq_drv, dqs_drv}, 1'b0);
    chk("R11", "en_async",  0, 30, |{dq_en, dqs_en}, 1'b0);
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_T * 50000);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    wrap_up();
  end

  initial begin
    rst_n = 1'b0;
    set_taps(0);
    drive_word(NW);
    test_reset_R1();
    test_order_R2_R3();
    test_oe_R4_R5();
    test_taps_R7_R8();
    test_same_R9();
    test_strobe_R10();
    test_midreset_R11();
    wrap_up();
  end
endmodule